// File: doc/BRIEF.md
# Byte-Select SRAM Bus Controller

This block drives a 32-bit asynchronous SRAM bus built from two 16-bit devices. Each device has an upper and a lower byte-select input, and four active-low byte strobes feed them. An internal master issues word requests. Each request carries a word address, a direction, byte enables, a burst flag and a wait setting. The controller runs the chip select, read strobe, direction line, byte strobes and data-bus enable in the right order. It returns read words on a per-beat valid pulse and flags the end of every request with a one-cycle done pulse.

The byte strobes do double duty. During writes they are ordinary write strobes. During reads, only the strobes for the requested bytes go low, so they act as byte selects. In both directions a strobe falls on a falling clock edge and rises on a rising clock edge. A burst moves 32 bytes as eight words. It starts at the requested word, wraps inside its aligned 8-word block, and keeps chip select low throughout.

Handshakes are as follows:
- Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request is taken on a rising edge where both `req_valid` and `req_ready` are high.
- Write data arrives one word per beat on a second valid/ready stream. A beat waits in its address phase, with chip select held low, until `wd_valid` is high.
- Responses cannot be back-pressured. The consumer must take `rsp_valid` and `rsp_done` in the cycle they appear.

Top module: `bcsram_ctrl`

## Requirements
- R1: After reset `bus_cs_n`, `bus_rd_n` and all four `bus_we_n` bits are 1, `bus_dq_oe` is 0 and `req_ready` is 1.
- R2: In a single read, only the `bus_we_n[i]` bits whose `req_be[i]` is 1 go low. Bit i of the strobes and of the enables belongs to data bits 8i+7 down to 8i.
- R3: Every byte strobe falls while the clock is low, at a falling edge, and rises on a rising edge. In reads it rises together with `bus_rd_n`, which changes only on rising edges and is low whenever a byte strobe is low.
- R4: A write uses the same strobe timing as a read: the strobes of the enabled bytes go low, and those bytes of the write word land in the SRAM while the other bytes are kept.
- R5: `cfg_wait` is sampled when a request is accepted. Each beat's strobe phase then lasts `cfg_wait`+1 clock cycles, whatever `cfg_wait` does later.
- R6: A burst runs 8 beats with all four byte strobes, whatever `req_be` holds. The first beat uses `req_addr` and each later beat the next word address, with the low 3 bits wrapping and the upper bits fixed.
- R7: Chip select stays low from the first beat of a request until its done pulse.
- R8: `bus_rdwr` is 1 for reads and 0 for writes. It is set at least one cycle before chip select falls and does not change while chip select is low.
- R9: `bus_dq_oe` is 1 only during writes, from the start of the strobe phase through one cycle after the strobes rise. It is 0 for all of a read.
- R10: Read data is captured at the rising edge that ends the read strobe. Each read beat gives one `rsp_valid` cycle carrying that word. Each request gives exactly one `rsp_done` cycle.
- R11: `req_ready` is 0 while chip select is low, and chip select is high for at least one cycle between two requests, even when they come back to back.
- R12: A write beat takes exactly one word from the data stream. Its strobes do not go low before that word has been handed over, and chip select stays low while the beat waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address of the (first) access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Byte enables for single accesses |
| req_burst | input | 1 | 1 = 32-byte wrap-around burst |
| cfg_wait | input | WAIT_W | Extra strobe cycles per beat |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Write word can be taken for the current beat |
| wd_data | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read word valid for one cycle |
| rsp_rdata | output | DATA_W | Read word |
| rsp_done | output | 1 | Request finished, one cycle |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rdwr | output | 1 | Direction, 1 = read |
| bus_we_n | output | DATA_W/8 | Byte strobes / byte selects, active low |
| bus_addr | output | ADDR_W | Word address on the bus |
| bus_dq_o | output | DATA_W | Write data toward the SRAM |
| bus_dq_oe | output | 1 | Data-bus drive enable |
| bus_dq_i | input | DATA_W | Read data from the SRAM |

## Verification
The bench builds the controller with its defaults: a 32-bit bus and 32-byte bursts, so each burst is eight beats, and a 3-bit wait field. This reaches the shortest strobe (wait 0, half a cycle of byte strobe) and the longest (wait 7, eight cycles). The 3-bit beat index it wraps makes both the mid-block wrap and the write-burst back-pressure path observable on the pins.

// File: rtl/bcsram_pkg.sv
package bcsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ADDR = 3'd2,
    ST_STRB = 3'd3,
    ST_HOLD = 3'd4
  } phase_e;
endpackage

// File: rtl/bcsram_addr_gen.sv
module bcsram_addr_gen #(
  parameter int WADDR_W = 22,
  parameter int BEATS   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WADDR_W-1:0] start_waddr,
  input  logic               advance,
  output logic [WADDR_W-1:0] waddr,
  output logic               last_beat
);
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [WADDR_W-1:IDX_W] base_q;
  logic [IDX_W-1:0]       idx_q;
  logic [IDX_W-1:0]       first_q;
  logic [IDX_W-1:0]       cnt_q;

  assign waddr     = {base_q, idx_q};
  assign last_beat = (cnt_q == IDX_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      idx_q   <= '0;
      first_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= start_waddr[WADDR_W-1:IDX_W];
      idx_q   <= start_waddr[IDX_W-1:0];
      first_q <= start_waddr[IDX_W-1:0];
      cnt_q   <= '0;
    end else if (advance) begin
      idx_q <= idx_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_LAST_PRECEDES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (idx_q == IDX_W'(first_q - 1'b1))); // R6
  AST_ADV_WITHIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last_beat); // R6
endmodule

// File: rtl/bcsram_strobe_gen.sv
module bcsram_strobe_gen #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_phase,
  input  logic             is_read,
  input  logic [LANES-1:0] lanes,
  output logic [LANES-1:0] we_n,
  output logic             rd_n
);
  // Armed on the falling edge inside the strobe phase; the phase itself,
  // a rising-edge register, cuts the strobe off on the closing rising edge.
  logic arm_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= strb_phase;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_n[g] = ~(arm_q & strb_phase & lanes[g]);
  end

  assign rd_n = ~(strb_phase & is_read);

  AST_ARM_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_phase && $past(strb_phase)) |-> arm_q); // R3
endmodule

// File: rtl/bcsram_seq.sv
module bcsram_seq
  import bcsram_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              wd_valid,
  input  logic              last_beat,
  output logic              req_ready,
  output logic              accept,
  output logic              advance,
  output logic              strb_phase,
  output logic              bus_active,
  output logic              is_read,
  output logic              oe,
  output logic              wd_ready,
  output logic              wd_take,
  output logic              capture,
  output logic              rsp_valid,
  output logic              rsp_done
);
  phase_e            state_q, nxt;
  logic [WAIT_W-1:0] wait_q, wcnt_q;
  logic              wr_q, bst_q, finish, done_q, val_q;
  logic [WAIT_W:0]   strb_len_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready & req_valid;
  assign strb_phase = (state_q == ST_STRB);
  assign bus_active = (state_q == ST_ADDR) | (state_q == ST_STRB) | (state_q == ST_HOLD);
  assign is_read    = ~wr_q;
  assign oe         = wr_q & ((state_q == ST_STRB) | (state_q == ST_HOLD));
  assign wd_ready   = wr_q & (state_q == ST_ADDR);
  assign wd_take    = wd_ready & wd_valid;
  assign capture    = strb_phase & (wcnt_q == '0) & ~wr_q;
  assign rsp_valid  = val_q;
  assign rsp_done   = done_q;

  always_comb begin
    nxt     = state_q;
    finish  = 1'b0;
    advance = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) nxt = ST_PRE;
      ST_PRE:  nxt = ST_ADDR;
      ST_ADDR: if (!wr_q || wd_valid) nxt = ST_STRB;
      ST_STRB: begin
        if (wcnt_q == '0) begin
          if (wr_q) begin
            nxt = ST_HOLD;
          end else if (bst_q && !last_beat) begin
            nxt     = ST_ADDR;
            advance = 1'b1;
          end else begin
            nxt    = ST_IDLE;
            finish = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (bst_q && !last_beat) begin
          nxt     = ST_ADDR;
          advance = 1'b1;
        end else begin
          nxt    = ST_IDLE;
          finish = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      wcnt_q  <= '0;
      wr_q    <= 1'b0;
      bst_q   <= 1'b0;
      done_q  <= 1'b0;
      val_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      done_q  <= finish;
      val_q   <= capture;
      if (accept) begin
        wait_q <= cfg_wait;
        wr_q   <= req_write;
        bst_q  <= req_burst;
      end
      if (state_q == ST_ADDR && nxt == ST_STRB) wcnt_q <= wait_q;
      else if (strb_phase && wcnt_q != '0)      wcnt_q <= wcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          strb_len_q <= '0;
    else if (strb_phase) strb_len_q <= strb_len_q + 1'b1;
    else                 strb_len_q <= '0;
  end

  AST_STRB_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_phase) |-> (strb_len_q == ({1'b0, wait_q} + 1'b1))); // R5
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_active) |=> !bus_active); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10
  AST_WR_WAITS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && wr_q && !wd_valid) |=> (state_q == ST_ADDR)); // R12
endmodule

// File: rtl/bcsram_ctrl.sv
module bcsram_ctrl #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 32,
  parameter int BURST_BYTES = 32,
  parameter int WAIT_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic                req_burst,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                wd_valid,
  output logic                wd_ready,
  input  logic [DATA_W-1:0]   wd_data,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_done,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_rdwr,
  output logic [DATA_W/8-1:0] bus_we_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_dq_o,
  output logic                bus_dq_oe,
  input  logic [DATA_W-1:0]   bus_dq_i
);
  localparam int LANES = DATA_W / 8;
  localparam int BEATS = BURST_BYTES / LANES;

  logic             accept, advance, strb_phase, bus_active, is_read;
  logic             oe, wd_take, capture, last_beat;
  logic [LANES-1:0] be_q;
  logic             rdwr_q;
  logic [DATA_W-1:0] wd_q, rd_q;

  bcsram_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_burst  (req_burst),
    .cfg_wait   (cfg_wait),
    .wd_valid   (wd_valid),
    .last_beat  (last_beat),
    .req_ready  (req_ready),
    .accept     (accept),
    .advance    (advance),
    .strb_phase (strb_phase),
    .bus_active (bus_active),
    .is_read    (is_read),
    .oe         (oe),
    .wd_ready   (wd_ready),
    .wd_take    (wd_take),
    .capture    (capture),
    .rsp_valid  (rsp_valid),
    .rsp_done   (rsp_done)
  );

  bcsram_addr_gen #(.WADDR_W(ADDR_W), .BEATS(BEATS)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .start_waddr (req_addr),
    .advance     (advance),
    .waddr       (bus_addr),
    .last_beat   (last_beat)
  );

  bcsram_strobe_gen #(.LANES(LANES)) u_strb (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_phase (strb_phase),
    .is_read    (is_read),
    .lanes      (be_q),
    .we_n       (bus_we_n),
    .rd_n       (bus_rd_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q   <= '0;
      rdwr_q <= 1'b1;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (accept) begin
        be_q   <= req_burst ? {LANES{1'b1}} : req_be;
        rdwr_q <= ~req_write;
      end
      if (wd_take) wd_q <= wd_data;
      if (capture) rd_q <= bus_dq_i;
    end
  end

  assign bus_cs_n  = ~bus_active;
  assign bus_rdwr  = rdwr_q;
  assign bus_dq_o  = wd_q;
  assign bus_dq_oe = oe;
  assign rsp_rdata = rd_q;

  AST_RDWR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_rdwr)); // R8
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dq_oe |-> !bus_rdwr); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !req_ready); // R11
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_RD_COVERS_STRB: assert property (@(negedge clk) disable iff (!rst_n)
      (bus_rdwr && !bus_we_n[g]) |-> !bus_rd_n); // R3
  end
endmodule

// File: tb/tb_bcsram_ctrl.sv
`timescale 1ns/1ps
module tb_bcsram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [2:0]  cfg_wait = '0;
  logic        wd_valid = 1'b0;
  logic [31:0] wd_data = '0;
  logic        req_ready, wd_ready, rsp_valid, rsp_done;
  logic [31:0] rsp_rdata, bus_dq_o, bus_dq_i;
  logic        bus_cs_n, bus_rd_n, bus_rdwr, bus_dq_oe;
  logic [3:0]  bus_we_n;
  logic [21:0] bus_addr;

  always #4 clk = ~clk;

  bcsram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_burst(req_burst), .cfg_wait(cfg_wait), .wd_valid(wd_valid),
    .wd_ready(wd_ready), .wd_data(wd_data), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_rdwr(bus_rdwr), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
    .bus_dq_i(bus_dq_i)
  );

  int checks = 0, errors = 0;

  function automatic logic [31:0] pat(input logic [7:0] w);
    pat = {w ^ 8'hA5, w + 8'h3C, ~w, {w[3:0], w[7:4]}};
  endfunction

  // SRAM model: each byte lane answers only while its strobe is low.
  logic [31:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = pat(i[7:0]);

  always_comb begin
    for (int i = 0; i < 4; i++)
      bus_dq_i[8*i +: 8] = (!bus_cs_n && !bus_rd_n && !bus_we_n[i]) ?
                           mem[bus_addr[7:0]][8*i +: 8] : 8'h00;
  end

  logic [3:0] we_prev = 4'hF;
  int edge_err = 0;
  always @(bus_we_n) begin
    if (rst_n === 1'b1) begin
      for (int i = 0; i < 4; i++) begin
        if (we_prev[i] === 1'b1 && bus_we_n[i] === 1'b0 && clk !== 1'b0) edge_err++;
        if (we_prev[i] === 1'b0 && bus_we_n[i] === 1'b1) begin
          if (clk !== 1'b1) edge_err++;
          if (!bus_cs_n && !bus_rdwr) mem[bus_addr[7:0]][8*i +: 8] = bus_dq_o[8*i +: 8];
        end
      end
    end
    we_prev = bus_we_n;
  end
  always @(bus_rd_n) if (rst_n === 1'b1 && clk !== 1'b1) edge_err++;

  // Write-data stream driver.
  int wd_n = 0, wd_idx = 0, wd_delay = 0;
  logic [31:0] wq [0:7];
  bit hs_pend = 1'b0;
  always @(negedge clk) begin
    if (hs_pend) wd_idx++;
    if (wd_delay > 0) begin
      wd_delay--;
      wd_valid = 1'b0;
    end else if (wd_idx < wd_n) begin
      wd_valid = 1'b1;
      wd_data  = wq[wd_idx];
    end else wd_valid = 1'b0;
    hs_pend = wd_valid && wd_ready;
  end

  // Mid-cycle monitor.
  int nb, nv, ndone, cs_hi_mid, oe_rd, oe_seen, rdwr_chg, ready_busy, gap;
  int we_out_rd, strobe_nodata, cur_len;
  bit cs_seen, cs_relow, strb_prev, rdwr_first;
  logic [3:0]  we_mask;
  logic [21:0] addr_log [0:15];
  int          len_log  [0:15];
  logic [31:0] rdata_log[0:15];

  task automatic clr();
    nb = 0; nv = 0; ndone = 0; cs_hi_mid = 0; oe_rd = 0; oe_seen = 0;
    rdwr_chg = 0; ready_busy = 0; gap = 0; we_out_rd = 0; strobe_nodata = 0;
    cur_len = 0; cs_seen = 0; cs_relow = 0; strb_prev = 0; we_mask = 4'h0;
    wd_idx = 0; wd_n = 0; wd_delay = 0; hs_pend = 0;
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (rsp_done) ndone++;
      if (rsp_valid && nv < 16) begin rdata_log[nv] = rsp_rdata; nv++; end
      if ((!bus_rd_n || bus_we_n != 4'hF) && !strb_prev && nb < 16) begin
        addr_log[nb] = bus_addr; nb++; cur_len = 0;
      end
      if (!bus_rd_n || bus_we_n != 4'hF) begin
        cur_len++;
        if (!bus_rdwr && wd_idx < nb) strobe_nodata++;
      end
      if (bus_rd_n && bus_we_n == 4'hF && strb_prev && nb > 0) len_log[nb-1] = cur_len;
      strb_prev = (!bus_rd_n || bus_we_n != 4'hF);
      we_mask = we_mask | ~bus_we_n;
      if (bus_rd_n && bus_rdwr && bus_we_n != 4'hF) we_out_rd++;
      if (!bus_cs_n) begin
        if (!cs_seen) rdwr_first = bus_rdwr;
        cs_seen = 1;
        if (bus_rdwr !== rdwr_first) rdwr_chg++;
        if (req_ready) ready_busy++;
      end else if (cs_seen && ndone == 0) cs_hi_mid++;
      if (bus_dq_oe && bus_rdwr) oe_rd++;
      if (bus_dq_oe) oe_seen++;
      if (ndone > 0 && bus_cs_n && !cs_relow) gap++;
      if (ndone > 0 && !bus_cs_n) cs_relow = 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input int n);
    for (int k = 0; k < 600 && ndone < n; k++) @(negedge clk);
    chk("R10 done reached", 64'(ndone >= n), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [21:0] a, input logic wr, input logic [3:0] be,
                       input logic bst, input logic [2:0] w, input logic [2:0] w_after);
    @(negedge clk);
    req_addr = a; req_write = wr; req_be = be; req_burst = bst;
    cfg_wait = w; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_wait = w_after;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cs_n", 64'(bus_cs_n), 64'd1);
    chk("R1 rd_n", 64'(bus_rd_n), 64'd1);
    chk("R1 we_n", 64'(bus_we_n), 64'hF);
    chk("R1 oe", 64'(bus_dq_oe), 64'd0);
    chk("R1 ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_single_read();
    clr();
    issue(22'h10, 1'b0, 4'b0101, 1'b0, 3'd2, 3'd2);
    wait_done(1);
    chk("R2 strobed lanes", 64'(we_mask), 64'h5);
    chk("R3 strobe outside rd", 64'(we_out_rd), 64'd0);
    chk("R5 strobe length w2", 64'(len_log[0]), 64'd3);
    chk("R10 rdata", 64'(rdata_log[0]), 64'(pat(8'h10) & 32'h00FF00FF));
    chk("R10 valid count", 64'(nv), 64'd1);
    chk("R8 rdwr read", 64'(rdwr_first), 64'd1);
    chk("R9 no oe in read", 64'(oe_seen), 64'd0);
  endtask

  task automatic t_write_then_read();
    logic [31:0] exp;
    clr();
    wq[0] = 32'hDEADBEEF; wd_n = 1;
    issue(22'h20, 1'b1, 4'b1001, 1'b0, 3'd0, 3'd0);
    wait_done(1);
    chk("R4 write lanes", 64'(we_mask), 64'h9);
    chk("R5 strobe length w0", 64'(len_log[0]), 64'd1);
    chk("R8 rdwr write", 64'(rdwr_first), 64'd0);
    chk("R8 rdwr stable", 64'(rdwr_chg), 64'd0);
    chk("R9 oe cycles", 64'(oe_seen), 64'd2);
    chk("R12 one word used", 64'(wd_idx), 64'd1);
    exp = (pat(8'h20) & 32'h00FFFF00) | 32'hDE0000EF;
    clr();
    issue(22'h20, 1'b0, 4'hF, 1'b0, 3'd1, 3'd1);
    wait_done(1);
    chk("R4 merged readback", 64'(rdata_log[0]), 64'(exp));
  endtask

  task automatic t_wait_sampled();
    clr();
    issue(22'h33, 1'b0, 4'hF, 1'b0, 3'd7, 3'd0);
    wait_done(1);
    chk("R5 w7 kept after change", 64'(len_log[0]), 64'd8);
    chk("R3 edge timing", 64'(edge_err), 64'd0);
  endtask

  task automatic t_burst_read();
    logic [7:0] w;
    clr();
    issue(22'h15, 1'b0, 4'b0001, 1'b1, 3'd1, 3'd1);
    wait_done(1);
    chk("R6 beats", 64'(nb), 64'd8);
    chk("R6 all lanes", 64'(we_mask), 64'hF);
    chk("R10 valid per beat", 64'(nv), 64'd8);
    chk("R7 cs held", 64'(cs_hi_mid), 64'd0);
    chk("R10 one done", 64'(ndone), 64'd1);
    for (int k = 0; k < 8; k++) begin
      w = 8'h10 + 8'((5 + k) % 8);
      chk("R6 wrap order", 64'(addr_log[k]), 64'(w));
      chk("R10 burst data", 64'(rdata_log[k]), 64'(pat(w)));
    end
  endtask

  task automatic t_burst_write();
    clr();
    for (int k = 0; k < 8; k++) wq[k] = 32'hC0DE0000 + 32'(k);
    wd_n = 8; wd_delay = 5;
    issue(22'h3E, 1'b1, 4'b0010, 1'b1, 3'd0, 3'd0);
    wait_done(1);
    chk("R12 words used", 64'(wd_idx), 64'd8);
    chk("R12 strobe before data", 64'(strobe_nodata), 64'd0);
    chk("R7 cs held while waiting", 64'(cs_hi_mid), 64'd0);
    chk("R6 write first word", 64'(addr_log[0]), 64'h3E);
    chk("R6 write wrap", 64'(addr_log[2]), 64'h38);
    clr();
    issue(22'h38, 1'b0, 4'hF, 1'b1, 3'd0, 3'd0);
    wait_done(1);
    for (int k = 0; k < 8; k++)
      chk("R4 burst write data", 64'(rdata_log[k]), 64'(wq[(k + 2) % 8]));
  endtask

  task automatic t_back_to_back();
    clr();
    @(negedge clk);
    req_addr = 22'h05; req_write = 1'b0; req_be = 4'hF; req_burst = 1'b0;
    cfg_wait = 3'd0; req_valid = 1'b1;
    @(posedge clk); #1;
    req_addr = 22'h06;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_done(2);
    chk("R11 cs gap", 64'(gap >= 1), 64'd1);
    chk("R11 ready low while busy", 64'(ready_busy), 64'd0);
    chk("R10 two words", 64'(nv), 64'd2);
    chk("R10 second word", 64'(rdata_log[1]), 64'(pat(8'h06)));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single_read();
    t_write_then_read();
    t_wait_sampled();
    t_burst_read();
    t_burst_write();
    t_back_to_back();
    chk("R3 edges overall", 64'(edge_err), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule